// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked single-port memory whose 18-bit word is split into two 9-bit byte lanes. Address, control and write data are captured on the rising clock edge. Read data passes through an output register, so each read shows up one edge after the edge at which the array is accessed.

A burst starts from one of two address strobes: a processor-side strobe that can only begin reads, and a controller-side strobe that can begin reads or writes. After that, a 2-bit burst counter produces the following addresses. The counter steps when an advance input is asserted and holds when it is not. A static mode input chooses how the counter works: it either adds an offset to the starting low address bits or XORs the offset into them.

Three chip enables decide whether a strobe selects the memory. Byte-lane and global write inputs choose which lanes are written. An unclocked output enable gates the modelled tri-state output. That output is provided as separate `d_in`, `q_out` and `q_oe` ports.

Top module: `pburst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block becomes deselected with an empty read pipeline. After reset, `q_oe` is 0, and cycles with both strobes high produce no read output until a new strobe selects the memory.
- R2: When `adsp_n` is 0 and `ce1_n` is 0 and all enables are true, the address is latched and a read begins. `gw_n`, `we_n` and `bw_n` are ignored in that cycle, so no lane is written.
- R3: When `adsp_n` is 0 but `ce1_n` is 1, the processor strobe has no effect. The cycle is then decided by `adsc_n`, or it is a continue/idle cycle if `adsc_n` is 1.
- R4: Chip enable is true only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A taken strobe with chip enable false deselects the block. `q_oe` is then 0 after the second edge counted from that sample, and later cycles with both strobes high do nothing.
- R5: When `adsc_n` is 0 (and the processor strobe is not taken) and chip enable is true, the address is latched. A write begins if a write is requested; otherwise a read begins.
- R6: A write is requested when `gw_n`=0, or when `we_n`=0 with at least one `bw_n` bit at 0. With `gw_n`=0, both lanes are written. Otherwise `bw_n[0]`=0 writes bits [8:0] and `bw_n[1]`=0 writes bits [17:9].
- R7: With `burst_ilv`=0, the access at burst offset n uses low address bits (start + n) mod 4. The upper address bits stay fixed.
- R8: With `burst_ilv`=1, the access at burst offset n uses low address bits start XOR n.
- R9: In a cycle with both strobes high during an active burst, `adv_n`=0 steps the offset by one and `adv_n`=1 repeats the current address. Each such cycle reads or writes according to the write controls of that cycle.
- R10: A read sampled at edge k presents the addressed word on `q_out` with `q_oe`=1 after edge k+1, provided `oe_n` is 0. The word includes writes sampled at edge k or earlier.
- R11: `oe_n` is not clocked. Raising it drops `q_oe` at once without a clock edge. `q_out` is all zeros whenever `q_oe` is 0.
- R12: A write sampled at edge k leaves `q_oe` at 0 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | External word address |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low (also gates the processor strobe) |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| we_n | input | 1 | Byte write enable, active low |
| bw_n | input | 2 | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 add, 1 XOR |
| d_in | input | 18 | Write data |
| q_out | output | 18 | Read data, zero when not driven |
| q_oe | output | 1 | Output drive flag |

## Verification
The hardest case to reach from the ports is a burst that continues after a strobe cycle. In that case the next address depends on the stored start address, the counter offset, the chosen order and whether the advance input steps or holds. Write and read cycles can also interleave within the same burst. A second hard case is a processor strobe with `ce1_n` high, which has to hand the cycle to the controller strobe.

Directed sequences cover four things:
- full wrapping bursts in both orders, with holds in between;
- byte-lane writes followed by reads of the same words;
- both ignored-strobe cases;
- deselects.

A long seeded random run then mixes strobes, enables, advance, write controls and output-enable changes. Every cycle of that run is compared with a bench reference model.

// File: rtl/pburst_pkg.sv
// Shared parameters and helpers for the pipelined burst SRAM.
// Assumes the burst counter is always 2 bits wide (four-beat bursts).
package pburst_pkg;

    localparam int BURST_BITS = 2;

    // Low address bits for a given burst offset, in either order.
    function automatic logic [BURST_BITS-1:0] burst_lsb(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  ilv
    );
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/pburst_ctrl.sv
// Cycle decoder and burst address generator.
// Decides from the strobes, enables and write controls whether this cycle
// reads, writes or deselects, and produces the array address for it.
// Assumes AW >= 2; burst_ilv is static while a burst runs.
module pburst_ctrl
    import pburst_pkg::*;
#(
    parameter int AW    = 6,
    parameter int NLANE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             we_n,
    input  logic [NLANE-1:0] bw_n,
    input  logic             burst_ilv,
    output logic [AW-1:0]    acc_addr,
    output logic [NLANE-1:0] lane_we,
    output logic             rd_go
);
    localparam int BB = BURST_BITS;

    logic             active;
    logic [AW-1:0]    base;
    logic [BB-1:0]    cnt;

    logic             adsp_take;
    logic             adsc_take;
    logic             strobe;
    logic             en_ok;
    logic             wr_req;
    logic [BB-1:0]    step_cnt;
    logic [NLANE-1:0] mask;

    // Strobe priority, enable and write-request decode.
    always_comb begin
        adsp_take = !adsp_n && !ce1_n;
        adsc_take = !adsc_n && !adsp_take;
        strobe    = adsp_take || adsc_take;
        en_ok     = !ce1_n && ce2 && !ce3_n;
        wr_req    = !gw_n || (!we_n && !(&bw_n));
        step_cnt  = cnt + {{(BB-1){1'b0}}, !adv_n};
    end

    // Per-lane write mask: global write overrides the lane selects.
    for (genvar i = 0; i < NLANE; i++) begin : g_mask
        assign mask[i] = !gw_n || (!we_n && !bw_n[i]);
    end

    // Cycle type and access address for the current cycle.
    always_comb begin
        acc_addr = addr;
        lane_we  = '0;
        rd_go    = 1'b0;
        if (strobe) begin
            if (en_ok) begin
                if (adsc_take && wr_req) lane_we = mask;
                else                     rd_go   = 1'b1;
            end
        end else if (active) begin
            acc_addr = {base[AW-1:BB], burst_lsb(base[BB-1:0], step_cnt, burst_ilv)};
            if (wr_req) lane_we = mask;
            else        rd_go   = 1'b1;
        end
    end

    // Burst state: selection flag, start address and offset counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            cnt    <= '0;
        end else if (strobe) begin
            active <= en_ok;
            base   <= addr;
            cnt    <= '0;
        end else if (active) begin
            cnt <= step_cnt;
        end
    end

    // R2: a taken processor strobe never writes.
    a_r2_adsp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (lane_we == '0));

    // R9: a hold cycle keeps the burst offset.
    a_r9_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adsp_n && adsc_n && adv_n) |=> $stable(cnt));

    // R6: a global write in a write cycle enables every lane.
    a_r6_global_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_we != '0) && !gw_n) |-> (&lane_we));

endmodule

// File: rtl/pburst_array.sv
// Storage array: one word per address, split into independently written lanes.
// Assumes the write and the read address may differ in the same cycle; the
// read port is combinational and reflects writes from earlier edges only.
module pburst_array #(
    parameter int AW     = 6,
    parameter int NLANE  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [AW-1:0]           wr_addr,
    input  logic [NLANE-1:0]        lane_we,
    input  logic [NLANE*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [NLANE*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Lane write on the rising edge when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[i]) lane_mem[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
        end

        assign rd_data[i*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/pburst_outpipe.sv
// Read pipeline: holds the read request for the array cycle, then registers
// the array word and gates it with the asynchronous output enable.
// Assumes rd_go and acc_addr are valid at every rising edge.
module pburst_outpipe #(
    parameter int AW = 6,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic          oe_n,
    output logic [AW-1:0] rd_addr_q,
    output logic [DW-1:0] q_out,
    output logic          q_oe
);
    logic          rd_pend;
    logic          out_vld;
    logic [DW-1:0] out_data;

    // Access stage: remember which address is read in the coming cycle.
    always_ff @(posedge clk) begin
        rd_addr_q <= acc_addr;
        if (!rst_n) rd_pend <= 1'b0;
        else        rd_pend <= rd_go;
    end

    // Output stage: capture the array word and its validity.
    always_ff @(posedge clk) begin
        out_data <= arr_rdata;
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= rd_pend;
    end

    // Unclocked output gating.
    always_comb begin
        q_oe  = out_vld && !oe_n;
        q_out = q_oe ? out_data : '0;
    end

    // R10: valid output follows a pending read by exactly one edge.
    a_r10_pipe_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !oe_n) |=> (out_vld || !$past(rst_n)) );

endmodule

// File: rtl/pburst_sram.sv
// Pipelined burst synchronous SRAM, top level.
// Wires the cycle decoder, lane array and read pipeline together.
// Assumes burst_ilv is held static by the system.
module pburst_sram #(
    parameter int AW     = 6,
    parameter int NLANE  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    we_n,
    input  logic [NLANE-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic [NLANE*LANE_W-1:0] d_in,
    output logic [NLANE*LANE_W-1:0] q_out,
    output logic                    q_oe
);
    localparam int DW = NLANE * LANE_W;

    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    rd_addr_q;
    logic [NLANE-1:0] lane_we;
    logic             rd_go;
    logic [DW-1:0]    arr_rdata;
    logic             desel;

    pburst_ctrl #(.AW(AW), .NLANE(NLANE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .we_n(we_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
        .acc_addr(acc_addr), .lane_we(lane_we), .rd_go(rd_go)
    );

    pburst_array #(.AW(AW), .NLANE(NLANE), .LANE_W(LANE_W)) array_i (
        .clk(clk), .wr_addr(acc_addr), .lane_we(lane_we), .wr_data(d_in),
        .rd_addr(rd_addr_q), .rd_data(arr_rdata)
    );

    pburst_outpipe #(.AW(AW), .DW(DW)) pipe_i (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .acc_addr(acc_addr),
        .arr_rdata(arr_rdata), .oe_n(oe_n), .rd_addr_q(rd_addr_q),
        .q_out(q_out), .q_oe(q_oe)
    );

    // Port-level deselect condition: a taken strobe with enables false.
    assign desel = ((!adsp_n && !ce1_n) || !adsc_n) && !(!ce1_n && ce2 && !ce3_n);

    // R4: deselect sampled at edge k leaves the output undriven after k+1.
    a_r4_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(desel, 2) |-> !q_oe);

    // R12: a write cycle leaves the output undriven after the next edge.
    a_r12_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|lane_we, 2) |-> !q_oe);

endmodule

// File: tb/pburst_sram_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random cycles,
// compared every cycle against a reference model built from the requirements.
module pburst_sram_tb_top;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          gw_n = 1'b1, we_n = 1'b1;
    logic [1:0]    bw_n = 2'b11;
    logic          oe_n = 1'b0, burst_ilv = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] q_out;
    logic          q_oe;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_paddr = '0;
    logic          m_vld = 1'b0;
    logic [DW-1:0] m_data = '0;

    always #(CLK_P/2) clk = ~clk;

    pburst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .burst_ilv(burst_ilv),
        .d_in(d_in), .q_out(q_out), .q_oe(q_oe)
    );

    function automatic logic [1:0] f_lsb(input logic [1:0] s, input logic [1:0] n,
                                         input logic ilv);
        if (ilv) return s ^ n;
        return 2'((s + n) % 4);
    endfunction

    function automatic logic [DW-1:0] f_pattern(input int a);
        return DW'((a * 32'h2f1b) ^ 32'h155aa);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Model update for one rising edge, from the requirements.
    task automatic model_edge();
        logic          p_take, c_take, en, wr;
        logic [1:0]    msk;
        logic [1:0]    ncnt;
        logic [AW-1:0] a;
        logic          rd;
        if (!rst_n) begin
            m_act = 1'b0; m_pend = 1'b0; m_vld = 1'b0; m_cnt = '0;
            return;
        end
        m_vld  = m_pend;
        m_data = m_mem[m_paddr];
        p_take = !adsp_n && !ce1_n;
        c_take = !adsc_n && !p_take;
        en     = !ce1_n && ce2 && !ce3_n;
        wr     = !gw_n || (!we_n && bw_n != 2'b11);
        msk[0] = !gw_n || (!we_n && !bw_n[0]);
        msk[1] = !gw_n || (!we_n && !bw_n[1]);
        rd = 1'b0; a = addr;
        if (p_take || c_take) begin
            m_act = en; m_base = addr; m_cnt = '0;
            if (en) begin
                if (c_take && wr) begin
                    if (msk[0]) m_mem[addr][8:0]  = d_in[8:0];
                    if (msk[1]) m_mem[addr][17:9] = d_in[17:9];
                end else rd = 1'b1;
            end
        end else if (m_act) begin
            ncnt  = adv_n ? m_cnt : 2'(m_cnt + 2'd1);
            m_cnt = ncnt;
            a     = {m_base[AW-1:2], f_lsb(m_base[1:0], ncnt, burst_ilv)};
            if (wr) begin
                if (msk[0]) m_mem[a][8:0]  = d_in[8:0];
                if (msk[1]) m_mem[a][17:9] = d_in[17:9];
            end else rd = 1'b1;
        end
        m_pend  = rd;
        m_paddr = a;
    endtask

    task automatic compare();
        logic          e_oe;
        logic [DW-1:0] e_q;
        e_oe = m_vld && !oe_n;
        e_q  = e_oe ? m_data : '0;
        checks++;
        if (q_oe !== e_oe || q_out !== e_q) begin
            errors++;
            $display("FAIL %s: q_oe=%0b q_out=%h expected q_oe=%0b q_out=%h",
                     cur_req, q_oe, q_out, e_oe, e_q);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic drv(input logic p, input logic c, input logic v, input logic e1,
                       input logic e2, input logic e3, input logic g, input logic w,
                       input logic [1:0] b, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        adsp_n = p; adsc_n = c; adv_n = v; ce1_n = e1; ce2 = e2; ce3_n = e3;
        gw_n = g; we_n = w; bw_n = b; addr = a; d_in = d;
    endtask

    // Idle continue cycle: both strobes high, read controls.
    task automatic idle(input logic v);
        drv(1, 1, v, 0, 1, 0, 1, 1, 2'b11, '0, '0);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL R10: watchdog expired, actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        @(negedge clk);

        // R1: reset state
        cur_req = "R1";
        drv(1, 1, 0, 0, 1, 0, 1, 1, 2'b11, '0, '0);
        tick(); tick();
        rst_n = 1'b1;
        tick(); tick(); tick();

        // R5 / R6: preload every word through controller strobe, global write
        cur_req = "R5";
        for (int i = 0; i < DEPTH; i++) begin
            drv(1, 0, 1, 0, 1, 0, 0, 1, 2'b11, AW'(i), f_pattern(i));
            tick();
        end

        // R2: processor strobe read with write controls asserted (ignored)
        cur_req = "R2";
        drv(0, 1, 1, 0, 1, 0, 0, 0, 2'b00, 6'd5, 18'h3ffff);
        tick(); idle(1); tick(); tick();
        drv(0, 1, 1, 0, 1, 0, 1, 1, 2'b11, 6'd5, '0);
        tick(); tick(); tick();

        // R3: processor strobe with ce1_n high is ignored; controller strobe decides
        cur_req = "R3";
        drv(0, 1, 1, 1, 1, 0, 1, 1, 2'b11, 6'd9, '0);
        tick(); tick(); tick();
        drv(0, 0, 1, 1, 1, 0, 1, 1, 2'b11, 6'd9, '0);
        tick(); tick(); tick();

        // R6: lane writes, then read back
        cur_req = "R6";
        drv(1, 0, 1, 0, 1, 0, 1, 0, 2'b10, 6'd12, 18'h2aaaa);
        tick();
        drv(1, 0, 1, 0, 1, 0, 1, 0, 2'b01, 6'd13, 18'h15555);
        tick();
        drv(1, 0, 1, 0, 1, 0, 1, 0, 2'b11, 6'd12, 18'h3ffff);
        tick(); tick();
        drv(1, 0, 1, 0, 1, 0, 1, 1, 2'b11, 6'd13, '0);
        tick(); tick(); tick();

        // R7: linear burst from low bits 2, wrapping
        cur_req = "R7";
        burst_ilv = 1'b0;
        drv(0, 1, 1, 0, 1, 0, 1, 1, 2'b11, 6'd22, '0);
        tick();
        for (int k = 0; k < 4; k++) begin idle(0); tick(); end
        tick();

        // R8: interleaved burst from low bits 3
        cur_req = "R8";
        burst_ilv = 1'b1;
        drv(0, 1, 1, 0, 1, 0, 1, 1, 2'b11, 6'd31, '0);
        tick();
        for (int k = 0; k < 4; k++) begin idle(0); tick(); end
        tick();

        // R9: hold cycles, then a burst write continuation
        cur_req = "R9";
        drv(1, 0, 1, 0, 1, 0, 1, 1, 2'b11, 6'd41, '0);
        tick();
        idle(1); tick(); idle(1); tick(); idle(0); tick();
        drv(1, 1, 0, 0, 1, 0, 0, 1, 2'b11, '0, 18'h0beef);
        tick();
        idle(1); tick(); tick();

        // R4: deselect through each enable, then idle continues do nothing
        cur_req = "R4";
        drv(1, 0, 1, 0, 0, 0, 1, 1, 2'b11, 6'd3, '0);
        tick(); idle(0); tick(); tick(); tick();
        drv(0, 1, 1, 0, 1, 1, 1, 1, 2'b11, 6'd3, '0);
        tick(); tick(); tick();

        // R10: back-to-back reads of different words
        cur_req = "R10";
        for (int k = 0; k < 4; k++) begin
            drv(1, 0, 1, 0, 1, 0, 1, 1, 2'b11, AW'(50 + k), '0);
            tick();
        end
        tick();

        // R11: output enable acts without a clock edge
        cur_req = "R11";
        drv(1, 0, 1, 0, 1, 0, 1, 1, 2'b11, 6'd7, '0);
        tick(); idle(1); tick();
        #1 oe_n = 1'b1; #1 compare();
        #1 oe_n = 1'b0; #1 compare();

        // R12: write right after a read
        cur_req = "R12";
        drv(1, 0, 1, 0, 1, 0, 0, 1, 2'b11, 6'd7, 18'h11111);
        tick(); tick();
        idle(1); tick(); tick();

        // Random mix
        cur_req = "R10";
        for (int n = 0; n < 3000; n++) begin
            if (n % 500 == 0) burst_ilv = $urandom_range(1);
            adsp_n = ($urandom_range(99) >= 20);
            adsc_n = ($urandom_range(99) >= 20);
            adv_n  = $urandom_range(1);
            ce1_n  = ($urandom_range(99) >= 85);
            ce2    = ($urandom_range(99) < 92);
            ce3_n  = ($urandom_range(99) >= 92);
            gw_n   = ($urandom_range(99) >= 10);
            we_n   = ($urandom_range(99) >= 30);
            bw_n   = 2'($urandom_range(3));
            oe_n   = ($urandom_range(99) >= 85);
            addr   = AW'($urandom_range(DEPTH - 1));
            d_in   = DW'($urandom);
            tick();
        end

        summary();
        $finish;
    end

endmodule